// File: doc/BRIEF.md
# Serial Flash Status and Configuration Register Guard

This block holds the status and configuration registers of a serial NOR flash, as seen from the instruction decoder. The decoder gives it one-cycle strobes for each decoded instruction: set the write-enable latch, write status, read status, write configuration, read configuration, and a program-or-erase request with its 24-bit byte address. The write-protect pin comes straight from the package. The block answers with the register contents, a read-data word, and the protected address window that the block-protect field and the top/bottom bit select. It also returns a grant or a protection-error pulse for each program or erase request.

The status register carries a four-bit protect size, a top/bottom select, a write-disable bit and the write-enable latch. When the write-disable bit is set and the write-protect pin is held low, the block is in hardware-locked mode and refuses every status write. The 16-bit configuration register stands in for non-volatile storage. It comes out of reset in the erased state, and no protection setting affects it. Every state-changing instruction first needs the write-enable latch set, and it clears the latch whether it runs or is refused.

Top module: `flash_sreg_guard`

## Requirements
- R1: After reset, status_q is 0x00, cfg_q is 0xFFFF, prot_none is 1, and rd_valid, pe_grant and prot_err are 0.
- R2: A cmd_wren strobe sets the write-enable latch, status_q bit 1, on the next clock edge.
- R3: When the latch is set and the block is not hardware-locked, cmd_wrsr loads wr_data bit 7 into the write-disable bit (status_q bit 7), wr_data bit 6 into the top/bottom bit (status_q bit 6) and wr_data bits 5:2 into the protect size (status_q bits 5:2), all on the next edge, and clears the latch. This includes clearing the write-disable bit itself.
- R4: hw_locked is 1 exactly when status_q bit 7 is 1 and wp_n is 0. In that state, cmd_wrsr leaves bits 7:2 unchanged and only clears the latch.
- R5: cmd_wrsr, cmd_wrcfg or cmd_pe given while the latch is clear has no effect: the registers keep their values and no pulse appears.
- R6: When the latch is set, cmd_wrcfg loads all 16 bits of wr_data into cfg_q on the next edge and clears the latch, whether or not the block is hardware-locked.
- R7: With the protect size at 0, prot_none is 1 and prot_lo and prot_hi are 0. With top/bottom at 0 and size N from 1 to 8, the window is [2^24 - 65536*2^(N-1), 0xFFFFFF].
- R8: With top/bottom at 1 and size N from 1 to 8, the window is [0, 65536*2^(N-1) - 1].
- R9: A protect size of 9 or more covers the whole array, [0, 0xFFFFFF], on either side.
- R10: When the latch is set, cmd_pe at an address inside the window raises prot_err for exactly the next cycle. At an address outside the window it raises pe_grant for exactly the next cycle instead. Either way the latch is cleared.
- R11: cmd_rdsr makes rd_valid 1 on the next cycle with rd_data = {8'h00, status_q}. cmd_rdcfg does the same with rd_data = cfg_q. When both are given in the same cycle, the status read wins.
- R12: When write strobes arrive in the same cycle, only one of them runs, in this priority: cmd_wrsr, then cmd_wrcfg, then cmd_pe, then cmd_wren.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Set the write-enable latch |
| cmd_wrsr | input | 1 | Write the status register |
| cmd_rdsr | input | 1 | Read the status register |
| cmd_wrcfg | input | 1 | Write the configuration register |
| cmd_rdcfg | input | 1 | Read the configuration register |
| cmd_pe | input | 1 | Program or erase request |
| wr_data | input | 16 | Write data for status (bits 7:0) or configuration |
| pe_addr | input | 24 | Byte address of the program or erase request |
| status_q | output | 8 | Status: 7 write-disable, 6 top/bottom, 5:2 size, 1 latch, 0 zero |
| cfg_q | output | 16 | Configuration register |
| hw_locked | output | 1 | Hardware-locked mode is active |
| prot_none | output | 1 | No region is protected |
| prot_lo | output | 24 | First protected byte address |
| prot_hi | output | 24 | Last protected byte address |
| pe_grant | output | 1 | One-cycle pulse: request passed to the array |
| prot_err | output | 1 | One-cycle pulse: request refused by protection |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 16 | Read data |

## Verification
The assertions check on every cycle that a locked status write leaves the protection fields frozen and that the write-enable strobe sets the latch. They also check that no write without the latch changes the status, the configuration or the request outcome, that grant and error never appear together or for two cycles in a row, and that the window is ordered and fills the whole array once the size saturates. Only the bench scenarios can show that the window boundaries are correct, byte for byte, for each size and side. The same holds for program addresses on either side of a boundary, for the write-disable bit releasing itself once the pin goes high, and for the priority between strobes given together.

// File: rtl/fsr_pkg.sv
// Package: shared field positions and the resolved write-operation type for
// the flash status/configuration guard. Assumes an 8-bit status layout.
package fsr_pkg;
    localparam int SR_SWD_BIT = 7;
    localparam int SR_TB_BIT  = 6;
    localparam int SR_BP_LSB  = 2;
    localparam int SR_WEL_BIT = 1;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRSR,
        OP_WRCFG,
        OP_PE
    } wr_op_e;

    // Resolve concurrent write strobes by fixed priority.
    function automatic wr_op_e pick_op(input logic wren, input logic wrsr,
                                       input logic wrcfg, input logic pe);
        if (wrsr)       return OP_WRSR;
        else if (wrcfg) return OP_WRCFG;
        else if (pe)    return OP_PE;
        else if (wren)  return OP_WREN;
        else            return OP_NONE;
    endfunction
endpackage

// File: rtl/fsr_status_reg.sv
// Status register: write-disable, top/bottom, protect size and write-enable
// latch. Assumes op has already been resolved to a single operation.
module fsr_status_reg
    import fsr_pkg::*;
#(
    parameter int BP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wr_op_e          op,
    input  logic [7:0]      wdat,
    input  logic            wp_n,
    output logic            swd,
    output logic            tb,
    output logic [BP_W-1:0] bp,
    output logic            wel,
    output logic            hw_lock
);
    // Hardware lock: write-disable set while the pin is held low.
    assign hw_lock = swd & ~wp_n;

    // Register update for latch set, status write and latch clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swd <= 1'b0;
            tb  <= 1'b0;
            bp  <= '0;
            wel <= 1'b0;
        end else begin
            case (op)
                OP_WREN: wel <= 1'b1;
                OP_WRSR: begin
                    if (wel) begin
                        wel <= 1'b0;
                        if (!hw_lock) begin
                            swd <= wdat[SR_SWD_BIT];
                            tb  <= wdat[SR_TB_BIT];
                            bp  <= wdat[SR_BP_LSB +: BP_W];
                        end
                    end
                end
                OP_WRCFG, OP_PE: if (wel) wel <= 1'b0;
                default: ;
            endcase
        end
    end

    a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRSR && hw_lock) |=> ($stable({swd, tb, bp}) && !wel));
    a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WREN) |=> wel);
    a_r5_sr_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRSR && !wel) |=> $stable({swd, tb, bp, wel}));
endmodule

// File: rtl/fsr_cfg_reg.sv
// Configuration register standing in for non-volatile storage; resets to the
// erased all-ones state. Assumes op is resolved and wel is the current latch.
module fsr_cfg_reg
    import fsr_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_op_e           op,
    input  logic             wel,
    input  logic [CFG_W-1:0] wdat,
    output logic [CFG_W-1:0] cfg
);
    // Load on an enabled configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cfg <= '1;
        else if (op == OP_WRCFG && wel)  cfg <= wdat;
    end

    a_r6_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRCFG && wel) |=> (cfg == $past(wdat)));
    a_r5_cfg_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRCFG && !wel) |=> $stable(cfg));
endmodule

// File: rtl/fsr_prot_range.sv
// Protected window from the size field and top/bottom bit. Size 0 protects
// nothing; each step doubles from one sector and saturates at the array.
module fsr_prot_range #(
    parameter int ADDR_W = 24,
    parameter int SECT_W = 16,
    parameter int BP_W   = 4
) (
    input  logic              tb,
    input  logic [BP_W-1:0]   bp,
    output logic              none,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam int SHIFT_MAX = ADDR_W - SECT_W;
    localparam int SZ_W      = ADDR_W + 1;

    logic [SZ_W-1:0] size_b;
    logic [SZ_W-1:0] full_b;
    int              sh;

    // Window size in bytes, saturating at the whole array.
    always_comb begin
        full_b = {1'b1, {ADDR_W{1'b0}}};
        if (bp == '0)                     sh = 0;
        else if (int'(bp) > SHIFT_MAX)    sh = SHIFT_MAX;
        else                              sh = int'(bp) - 1;
        size_b = {{(SZ_W-1){1'b0}}, 1'b1} << (SECT_W + sh);
    end

    // Window edges, anchored at the top or the bottom of the array.
    always_comb begin
        none = (bp == '0);
        if (none) begin
            lo = '0;
            hi = '0;
        end else if (tb) begin
            lo = '0;
            hi = ADDR_W'(size_b - 1'b1);
        end else begin
            lo = ADDR_W'(full_b - size_b);
            hi = '1;
        end
    end

    // Window sanity on every evaluation.
    always_comb begin
        if (!none) a_r7_ordered: assert (lo <= hi);
        if (int'(bp) > SHIFT_MAX) a_r9_whole_array: assert (lo == '0 && hi == '1);
    end
endmodule

// File: rtl/fsr_pe_check.sv
// Program/erase gate: compares the request address with the window and
// pulses grant or error for one cycle. Assumes the window reflects status.
module fsr_pe_check
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_op_e            op,
    input  logic              wel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              none,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              grant,
    output logic              err
);
    logic hit;

    // Address inside the protected window.
    assign hit = !none && (addr >= lo) && (addr <= hi);

    // One-cycle outcome pulse for an enabled request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            err   <= 1'b0;
        end else begin
            grant <= (op == OP_PE) && wel && !hit;
            err   <= (op == OP_PE) && wel && hit;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && err));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || err) |=> !(grant || err));
    a_r5_pe_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PE && !wel) |=> !(grant || err));
endmodule

// File: rtl/flash_sreg_guard.sv
// Top: resolves instruction strobes, holds status and configuration,
// derives the protected window, gates program/erase and serves reads.
module flash_sreg_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SECT_W = 16,
    parameter int BP_W   = 4,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrsr,
    input  logic              cmd_rdsr,
    input  logic              cmd_wrcfg,
    input  logic              cmd_rdcfg,
    input  logic              cmd_pe,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] pe_addr,
    output logic [7:0]        status_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              hw_locked,
    output logic              prot_none,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi,
    output logic              pe_grant,
    output logic              prot_err,
    output logic              rd_valid,
    output logic [CFG_W-1:0]  rd_data
);
    wr_op_e          op;
    logic            swd;
    logic            tb;
    logic [BP_W-1:0] bp;
    logic            wel;

    // Single operation per cycle, by fixed priority.
    assign op = pick_op(cmd_wren, cmd_wrsr, cmd_wrcfg, cmd_pe);

    fsr_status_reg #(.BP_W(BP_W)) u_status (
        .clk(clk), .rst_n(rst_n), .op(op), .wdat(wr_data[7:0]), .wp_n(wp_n),
        .swd(swd), .tb(tb), .bp(bp), .wel(wel), .hw_lock(hw_locked)
    );

    fsr_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .op(op), .wel(wel), .wdat(wr_data), .cfg(cfg_q)
    );

    fsr_prot_range #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BP_W(BP_W)) u_range (
        .tb(tb), .bp(bp), .none(prot_none), .lo(prot_lo), .hi(prot_hi)
    );

    fsr_pe_check #(.ADDR_W(ADDR_W)) u_pe (
        .clk(clk), .rst_n(rst_n), .op(op), .wel(wel), .addr(pe_addr),
        .none(prot_none), .lo(prot_lo), .hi(prot_hi),
        .grant(pe_grant), .err(prot_err)
    );

    // Packed status view.
    assign status_q = {swd, tb, bp, wel, 1'b0};

    // Registered read port; status read wins over configuration read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cmd_rdsr | cmd_rdcfg;
            if (cmd_rdsr)       rd_data <= CFG_W'(status_q);
            else if (cmd_rdcfg) rd_data <= cfg_q;
        end
    end

    a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdsr || cmd_rdcfg) |=> rd_valid);
    a_r4_lock_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hw_locked == (status_q[SR_SWD_BIT] && !wp_n));
endmodule

// File: tb/flash_sreg_guard_tb.sv
module flash_sreg_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_wren = 0, cmd_wrsr = 0, cmd_rdsr = 0;
    logic        cmd_wrcfg = 0, cmd_rdcfg = 0, cmd_pe = 0;
    logic [15:0] wr_data = '0;
    logic [23:0] pe_addr = '0;
    logic [7:0]  status_q;
    logic [15:0] cfg_q;
    logic        hw_locked, prot_none, pe_grant, prot_err, rd_valid;
    logic [23:0] prot_lo, prot_hi;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit          is_pe;
        logic [23:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    flash_sreg_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrsr(cmd_wrsr), .cmd_rdsr(cmd_rdsr),
        .cmd_wrcfg(cmd_wrcfg), .cmd_rdcfg(cmd_rdcfg), .cmd_pe(cmd_pe),
        .wr_data(wr_data), .pe_addr(pe_addr),
        .status_q(status_q), .cfg_q(cfg_q), .hw_locked(hw_locked),
        .prot_none(prot_none), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .pe_grant(pe_grant), .prot_err(prot_err),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe order: wren wrsr wrcfg pe rdsr rdcfg. Held for one clock edge.
    task automatic send(input logic [5:0] s, input logic [15:0] d, input logic [23:0] a);
        @(negedge clk);
        {cmd_wren, cmd_wrsr, cmd_wrcfg, cmd_pe, cmd_rdsr, cmd_rdcfg} = s;
        wr_data = d;
        pe_addr = a;
        @(negedge clk);
        {cmd_wren, cmd_wrsr, cmd_wrcfg, cmd_pe, cmd_rdsr, cmd_rdcfg} = '0;
    endtask

    task automatic push(input bit is_pe, input logic [23:0] v, input string req);
        exp_t e;
        e.is_pe = is_pe; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wren();             send(6'b100000, 16'h0, 24'h0); endtask
    task automatic wrsr(input logic [7:0] d);   send(6'b010000, {8'h0, d}, 24'h0); endtask
    task automatic wrcfg(input logic [15:0] d); send(6'b001000, d, 24'h0); endtask
    task automatic pe_req(input logic [23:0] a, input bit exp_err, input string req);
        push(1'b1, {23'h0, exp_err}, req);
        send(6'b000100, 16'h0, a);
    endtask
    task automatic rd_sr(input logic [7:0] e, input string req);
        push(1'b0, {16'h0, e}, req);
        send(6'b000010, 16'h0, 24'h0);
    endtask
    task automatic rd_cfg(input logic [15:0] e, input string req);
        push(1'b0, {8'h0, e}, req);
        send(6'b000001, 16'h0, 24'h0);
    endtask

    task automatic chk_window(input string req, input bit tbv, input int n);
        logic [24:0] sz;
        if (n == 0) begin
            chk(req, {31'h0, prot_none}, 32'h1);
            return;
        end
        sz = (n >= 9) ? 25'h1000000 : (25'h10000 << (n - 1));
        chk(req, {31'h0, prot_none}, 32'h0);
        if (tbv) begin
            chk(req, {8'h0, prot_lo}, 32'h0);
            chk(req, {8'h0, prot_hi}, {8'h0, 24'(sz - 1)});
        end else begin
            chk(req, {8'h0, prot_lo}, {8'h0, 24'(25'h1000000 - sz)});
            chk(req, {8'h0, prot_hi}, 32'h00FFFFFF);
        end
    endtask

    // Monitor: pops expectations as results appear.
    always @(negedge clk) begin
        if (rst_n && (rd_valid || pe_grant || prot_err)) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 unexpected result actual=%b%b%b expected=none",
                         rd_valid, pe_grant, prot_err);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_pe) begin
                    chk(e.req, {30'h0, prot_err, pe_grant}, e.val[0] ? 32'h2 : 32'h1);
                end else begin
                    chk(e.req, {16'h0, rd_data}, {8'h0, e.val});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {24'h0, status_q}, 32'h0);
        chk("R1", {16'h0, cfg_q}, 32'hFFFF);
        chk("R1", {29'h0, rd_valid, pe_grant, prot_err}, 32'h0);
        chk_window("R1", 1'b0, 0);
        rd_cfg(16'hFFFF, "R11");
        rd_sr(8'h00, "R11");
        // R5 status write without the latch
        wrsr(8'h8C);
        chk("R5", {24'h0, status_q}, 32'h0);
        // R2 latch set
        wren();
        chk("R2", {24'h0, status_q}, 32'h02);
        // R3 write size 3, top
        wrsr(8'h0C);
        chk("R3", {24'h0, status_q}, 32'h0C);
        chk_window("R7", 1'b0, 3);
        // R10 boundary addresses
        wren(); pe_req(24'hFC0000, 1'b1, "R10");
        wren(); pe_req(24'hFBFFFF, 1'b0, "R10");
        chk("R10", {24'h0, status_q}, 32'h0C);
        // R5 request without latch: no pulse
        pe_req_none: begin
            send(6'b000100, 16'h0, 24'hFFFFFF);
            chk("R5", {30'h0, pe_grant, prot_err}, 32'h0);
        end
        // R8 bottom window, size 1
        wren(); wrsr(8'h44);
        chk("R3", {24'h0, status_q}, 32'h44);
        chk_window("R8", 1'b1, 1);
        wren(); pe_req(24'h00FFFF, 1'b1, "R8");
        wren(); pe_req(24'h010000, 1'b0, "R8");
        // R7 size 8 top, R9 saturation
        wren(); wrsr(8'h20);
        chk_window("R7", 1'b0, 8);
        wren(); wrsr(8'h24);
        chk_window("R9", 1'b0, 9);
        wren(); wrsr(8'h7C);
        chk_window("R9", 1'b1, 15);
        wren(); pe_req(24'h000000, 1'b1, "R9");
        // R4 hardware lock
        wren(); wrsr(8'h8C);
        chk("R3", {24'h0, status_q}, 32'h8C);
        chk("R4", {31'h0, hw_locked}, 32'h0);
        wp_n = 1'b0;
        @(negedge clk);
        chk("R4", {31'h0, hw_locked}, 32'h1);
        wren(); wrsr(8'h00);
        chk("R4", {24'h0, status_q}, 32'h8C);
        // R6 configuration write while locked
        wren(); wrcfg(16'h1234);
        chk("R6", {16'h0, cfg_q}, 32'h1234);
        chk("R6", {24'h0, status_q}, 32'h8C);
        // R3 write-disable clears itself once the pin is high
        wp_n = 1'b1;
        wren(); wrsr(8'h00);
        chk("R3", {24'h0, status_q}, 32'h00);
        // R5 configuration write without latch
        wrcfg(16'hABCD);
        chk("R5", {16'h0, cfg_q}, 32'h1234);
        rd_cfg(16'h1234, "R11");
        // R12 simultaneous strobes: status write wins
        wren();
        send(6'b110000, 16'h0010, 24'h0);
        chk("R12", {24'h0, status_q}, 32'h10);
        // R11 both reads: status wins
        push(1'b0, 24'h000010, "R11");
        send(6'b000011, 16'h0, 24'h0);
        repeat (3) @(negedge clk);
        chk("R11", sb.size(), 32'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule